// File: doc/BRIEF.md
# Programmable Processor Clock Divider

This block derives the processor clock from one of four source clocks: main, sub, on-chip oscillator and PLL. Each source is presented as a one-cycle enable ("tick") in a single fast reference clock domain. The selected source is divided by a ratio picked by a 5-bit division code. Only ten ratios exist: 1, 2, 3, 4, 6, 8, 10, 12, 14 and 16. The sub clock is never divided.

The output is a one-cycle enable pulse (`cpu_tick`) and a registered clock-like level (`cpu_clk`). A bus clock pair (`bus_tick`, `bus_clk`) runs at the same rate.

The division code is held in a register inside the block. That register is loaded by a write strobe. It is forced to the divide-by-8 code at reset and whenever a stop or low-power request is present. A new code or source reaches the divider only at the end of the current output period, so no output period is ever cut short.

Top module: `cpu_clk_div`

## Requirements
- R1: `cpu_tick` is high for exactly one reference cycle once every N ticks of the active source, where N is the active ratio. It is high in the cycle after the reference edge that samples the Nth tick.
- R2: Code mapping:
  - 00000 gives 1; 00001 gives 2; 00010 gives 3; 00011 gives 4; 00100 gives 6; 00101 to 00111 give 1.
  - 01000 gives 8; 01001 gives 10; 01010 gives 12; 01011 gives 14; 01100 gives 16; 01101 to 11111 give 8.
- R3: After reset:
  - `cur_code` is 01000 and the active source is main (code 00) at ratio 8.
  - `cpu_tick` and `cpu_clk` are low.
  - The first pulse follows the eighth main tick.
- R4: While `stop_req` or `lp_req` is high, `cur_code` becomes 01000 on the next cycle. The forced value wins over a write in the same cycle.
- R5: With `src_sel` = 01 (sub) active, the divider is bypassed: every sub tick yields one pulse, whatever the code.
- R6: `src_sel` encodes 00 main, 01 sub, 10 oscillator, 11 PLL. Main, oscillator and PLL are divided by the coded ratio. Ticks of sources that are not active have no effect on the output.
- R7: `bus_tick` equals `cpu_tick` and `bus_clk` equals `cpu_clk` in every cycle.
- R8: A change of code or source takes effect only at the next output pulse. The period in progress completes at its old length.
- R9: `cpu_clk` rises together with each `cpu_tick`. For N > 1 it falls on the tick that brings the count within the period to (N+1)/2, rounded down. For N = 1 it stays high.
- R10: A write (`code_wr` high, no force request) loads `code_wdata` into `cur_code` on the next cycle. Without a write or force request, `cur_code` holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_tick | input | 4 | Source enables: bit0 main, bit1 sub, bit2 oscillator, bit3 PLL |
| src_sel | input | 2 | Source select (00 main, 01 sub, 10 osc, 11 PLL) |
| code_wr | input | 1 | Division code write strobe |
| code_wdata | input | 5 | Division code to write |
| stop_req | input | 1 | Stop entry request, forces code 01000 |
| lp_req | input | 1 | Low-power entry request, forces code 01000 |
| cur_code | output | 5 | Current division code register |
| cpu_tick | output | 1 | One-cycle processor clock enable |
| cpu_clk | output | 1 | Registered clock-like processor level |
| bus_tick | output | 1 | Bus clock enable, mirrors `cpu_tick` |
| bus_clk | output | 1 | Bus clock level, mirrors `cpu_clk` |

## Verification
Every one of the 32 code values is programmed, and the pulse spacing is measured in active-source ticks over several periods. This exposes a swapped or off-by-one table entry, or an unused code that falls to the wrong default. A code write is made in the middle of a 16-tick period to change the ratio to 1. A design that applied the change at once would emit a short period before the 16th tick. A force request is raised in the same cycle as a write, so a design that gives the write priority leaves a non-default code. The sub source is run with a large code programmed: a design that divides the sub source shows a spacing of 16 instead of 1.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

  localparam int unsigned CODE_W = 5;
  localparam int unsigned SRC_W  = 2;
  localparam int unsigned NUM_SRC = 4;

  localparam logic [CODE_W-1:0] CODE_DIV8 = 5'b01000;

  typedef enum logic [SRC_W-1:0] {
    SRC_MAIN = 2'd0,
    SRC_SUB  = 2'd1,
    SRC_OSC  = 2'd2,
    SRC_PLL  = 2'd3
  } src_e;

endpackage

// File: rtl/clkdiv_code_reg.sv
module clkdiv_code_reg
  import clkdiv_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CODE_W-1:0] wr_code,
  input  logic              force_req,
  output logic [CODE_W-1:0] code_q
);

  logic [CODE_W-1:0] code_d;
  logic              code_en;

  always_comb begin
    code_en = force_req | wr_en;
    if (force_req) code_d = CODE_DIV8;
    else           code_d = wr_code;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       code_q <= CODE_DIV8;
    else if (code_en) code_q <= code_d;
  end

endmodule

// File: rtl/clkdiv_ratio_dec.sv
module clkdiv_ratio_dec
  import clkdiv_pkg::*;
#(
  parameter int unsigned RATIO_W = 5
) (
  input  logic [CODE_W-1:0]  code,
  output logic [RATIO_W-1:0] ratio
);

  // Low bank: one-to-one small ratios, unused codes fall back to 1.
  // High bank: even ratios from 8 upward, unused codes fall back to 8.
  always_comb begin
    if (!code[4] && !code[3]) begin
      unique case (code[2:0])
        3'd0:    ratio = RATIO_W'(1);
        3'd1:    ratio = RATIO_W'(2);
        3'd2:    ratio = RATIO_W'(3);
        3'd3:    ratio = RATIO_W'(4);
        3'd4:    ratio = RATIO_W'(6);
        default: ratio = RATIO_W'(1);
      endcase
    end else if (!code[4]) begin
      unique case (code[2:0])
        3'd0:    ratio = RATIO_W'(8);
        3'd1:    ratio = RATIO_W'(10);
        3'd2:    ratio = RATIO_W'(12);
        3'd3:    ratio = RATIO_W'(14);
        3'd4:    ratio = RATIO_W'(16);
        default: ratio = RATIO_W'(8);
      endcase
    end else begin
      ratio = RATIO_W'(8);
    end
  end

endmodule

// File: rtl/clkdiv_period_ctr.sv
module clkdiv_period_ctr #(
  parameter int unsigned RATIO_W = 5,
  parameter int unsigned CNT_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick_in,
  input  logic [RATIO_W-1:0] ratio_act,
  output logic               period_end,
  output logic               tick_q,
  output logic               clk_q
);

  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [RATIO_W-1:0] cnt_ext, cnt_inc, mid_pt;
  logic               clk_d;

  always_comb begin
    cnt_ext    = RATIO_W'(cnt_q);
    cnt_inc    = cnt_ext + RATIO_W'(1);
    mid_pt     = (ratio_act + RATIO_W'(1)) >> 1;
    period_end = tick_in && (cnt_ext == ratio_act - RATIO_W'(1));

    cnt_d = cnt_q;
    if (tick_in) begin
      if (period_end) cnt_d = '0;
      else            cnt_d = cnt_q + CNT_W'(1);
    end

    clk_d = clk_q;
    if (period_end)
      clk_d = 1'b1;
    else if (tick_in && (cnt_inc == mid_pt) && (ratio_act != RATIO_W'(1)))
      clk_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
      clk_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      tick_q <= period_end;
      clk_q  <= clk_d;
    end
  end

endmodule

// File: rtl/cpu_clk_div.sv
module cpu_clk_div
  import clkdiv_pkg::*;
#(
  parameter int unsigned MAX_RATIO = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        src_tick,
  input  logic [1:0]        src_sel,
  input  logic              code_wr,
  input  logic [4:0]        code_wdata,
  input  logic              stop_req,
  input  logic              lp_req,
  output logic [4:0]        cur_code,
  output logic              cpu_tick,
  output logic              cpu_clk,
  output logic              bus_tick,
  output logic              bus_clk
);

  localparam int unsigned RATIO_W = $clog2(MAX_RATIO + 1);
  localparam int unsigned CNT_W   = $clog2(MAX_RATIO);

  logic [RATIO_W-1:0] dec_ratio, next_ratio;
  logic [RATIO_W-1:0] act_ratio;
  logic [SRC_W-1:0]   act_src;
  logic               sel_tick;
  logic               period_end;

  clkdiv_code_reg u_code (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (code_wr),
    .wr_code   (code_wdata),
    .force_req (stop_req | lp_req),
    .code_q    (cur_code)
  );

  clkdiv_ratio_dec #(.RATIO_W(RATIO_W)) u_dec (
    .code  (cur_code),
    .ratio (dec_ratio)
  );

  always_comb begin
    sel_tick = src_tick[act_src];
    if (src_sel == SRC_SUB) next_ratio = RATIO_W'(1);
    else                    next_ratio = dec_ratio;
  end

  // Active source and ratio only move at a period boundary.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_src   <= SRC_MAIN;
      act_ratio <= RATIO_W'(8);
    end else if (period_end) begin
      act_src   <= src_sel;
      act_ratio <= next_ratio;
    end
  end

  clkdiv_period_ctr #(.RATIO_W(RATIO_W), .CNT_W(CNT_W)) u_ctr (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_in    (sel_tick),
    .ratio_act  (act_ratio),
    .period_end (period_end),
    .tick_q     (cpu_tick),
    .clk_q      (cpu_clk)
  );

  assign bus_tick = cpu_tick;
  assign bus_clk  = cpu_clk;

endmodule

// File: rtl/clkdiv_checker.sv
module clkdiv_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       code_wr,
  input logic [4:0] code_wdata,
  input logic       stop_req,
  input logic       lp_req,
  input logic [4:0] cur_code,
  input logic       cpu_tick,
  input logic       cpu_clk,
  input logic       bus_tick,
  input logic       bus_clk,
  input logic       sel_tick,
  input logic [1:0] act_src
);

  assert_tick_after_src_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_tick |-> $past(sel_tick));

  assert_reset_state_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (cur_code == 5'b01000) && !cpu_tick);

  assert_force_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_req || lp_req) |=> (cur_code == 5'b01000));

  assert_sub_bypass_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (act_src == 2'b01 && sel_tick) |=> cpu_tick);

  assert_bus_mirror_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_tick == cpu_tick) && (bus_clk == cpu_clk));

  assert_clk_rises_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_tick |-> cpu_clk);

  assert_code_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (code_wr && !stop_req && !lp_req) |=> (cur_code == $past(code_wdata)));

  assert_code_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!code_wr && !stop_req && !lp_req) |=> $stable(cur_code));

endmodule

bind cpu_clk_div clkdiv_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .code_wr    (code_wr),
  .code_wdata (code_wdata),
  .stop_req   (stop_req),
  .lp_req     (lp_req),
  .cur_code   (cur_code),
  .cpu_tick   (cpu_tick),
  .cpu_clk    (cpu_clk),
  .bus_tick   (bus_tick),
  .bus_clk    (bus_clk),
  .sel_tick   (sel_tick),
  .act_src    (act_src)
);

// File: tb/tb_cpu_clk_div.sv
`timescale 1ns/1ps
module tb_cpu_clk_div;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] src_tick = '0;
  logic [1:0] src_sel = 2'b00;
  logic       code_wr = 1'b0;
  logic [4:0] code_wdata = '0;
  logic       stop_req = 1'b0;
  logic       lp_req = 1'b0;
  logic [4:0] cur_code;
  logic       cpu_tick, cpu_clk, bus_tick, bus_clk;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int run_ticks = 0;
  int last_gap = 0;
  int npulse = 0;
  int bus_err = 0;
  int clk_err = 0;
  int clk_low_seen = 0;

  always #10 clk = ~clk;

  cpu_clk_div dut (
    .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .src_sel(src_sel),
    .code_wr(code_wr), .code_wdata(code_wdata), .stop_req(stop_req),
    .lp_req(lp_req), .cur_code(cur_code), .cpu_tick(cpu_tick),
    .cpu_clk(cpu_clk), .bus_tick(bus_tick), .bus_clk(bus_clk)
  );

  // Source patterns: main every 2nd, sub every 3rd, osc every cycle, PLL odd phases.
  int phase = 0;
  always @(negedge clk) begin
    phase <= phase + 1;
    src_tick[0] <= (phase % 2 == 0);
    src_tick[1] <= (phase % 3 == 0);
    src_tick[2] <= 1'b1;
    src_tick[3] <= (phase % 2 == 1);
  end

  // Monitor: source ticks per pulse, measured after each edge.
  always @(posedge clk) begin
    #1;
    cycles++;
    if (rst_n) begin
      if (src_tick[src_sel]) run_ticks++;
      if (cpu_tick) begin
        last_gap = run_ticks;
        run_ticks = 0;
        npulse++;
        if (!cpu_clk) clk_err++;
      end
      if (bus_tick !== cpu_tick || bus_clk !== cpu_clk) bus_err++;
      if (!cpu_clk) clk_low_seen++;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_ratio(input logic [4:0] c);
    case (c)
      5'd0: return 1;  5'd1: return 2;  5'd2: return 3;
      5'd3: return 4;  5'd4: return 6;  5'd5, 5'd6, 5'd7: return 1;
      5'd8: return 8;  5'd9: return 10; 5'd10: return 12;
      5'd11: return 14; 5'd12: return 16;
      default: return 8;
    endcase
  endfunction

  task automatic wait_pulse();
    int s = npulse;
    while (npulse == s) begin
      @(posedge clk);
      #2;
    end
  endtask

  task automatic write_code(input logic [4:0] c);
    @(negedge clk);
    code_wr = 1'b1;
    code_wdata = c;
    @(negedge clk);
    code_wr = 1'b0;
  endtask

  task automatic measure(input int n, input string tag);
    wait_pulse();
    wait_pulse();
    for (int k = 0; k < 3; k++) begin
      wait_pulse();
      check(last_gap == n, tag, last_gap, n);
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(cur_code == 5'b01000, "R3 reset code", cur_code, 8);
    check(cpu_tick == 1'b0, "R3 reset tick", cpu_tick, 0);
    check(cpu_clk == 1'b0, "R3 reset clk", cpu_clk, 0);
    wait_pulse();
    check(last_gap == 8, "R3 first period main/8", last_gap, 8);
    measure(8, "R1 default spacing");
  endtask

  task automatic t_all_codes();
    src_sel = 2'b00;
    for (int c = 0; c < 32; c++) begin
      write_code(5'(c));
      check(cur_code == 5'(c), "R10 code write", cur_code, c);
      measure(exp_ratio(5'(c)), $sformatf("R2 code %0d spacing", c));
    end
  endtask

  task automatic t_force();
    write_code(5'd0);
    @(negedge clk);
    stop_req = 1'b1; code_wr = 1'b1; code_wdata = 5'd3;
    @(negedge clk);
    stop_req = 1'b0; code_wr = 1'b0;
    check(cur_code == 5'b01000, "R4 stop beats write", cur_code, 8);
    write_code(5'd2);
    @(negedge clk);
    lp_req = 1'b1;
    @(negedge clk);
    lp_req = 1'b0;
    check(cur_code == 5'b01000, "R4 low-power force", cur_code, 8);
    @(negedge clk);
    check(cur_code == 5'b01000, "R10 code holds", cur_code, 8);
    measure(8, "R4 forced ratio spacing");
  endtask

  task automatic t_sources();
    write_code(5'b01100);
    src_sel = 2'b01;
    measure(1, "R5 sub bypass");
    write_code(5'b00010);
    src_sel = 2'b10;
    measure(3, "R6 osc divided by 3");
    write_code(5'b01011);
    src_sel = 2'b11;
    measure(14, "R6 pll divided by 14");
    src_sel = 2'b00;
    write_code(5'b00011);
    measure(4, "R6 main ignores other sources");
  endtask

  task automatic t_boundary();
    write_code(5'b01100);
    measure(16, "R8 setup 16");
    wait_pulse();
    repeat (10) @(negedge clk);
    write_code(5'd0);
    wait_pulse();
    check(last_gap == 16, "R8 period completes at old ratio", last_gap, 16);
    wait_pulse();
    check(last_gap == 1, "R8 new ratio after boundary", last_gap, 1);
  endtask

  task automatic t_clk_shape();
    write_code(5'd0);
    measure(1, "R9 setup ratio 1");
    clk_low_seen = 0;
    repeat (20) @(negedge clk);
    check(clk_low_seen == 0, "R9 clk stays high at ratio 1", clk_low_seen, 0);
    write_code(5'b00011);
    measure(4, "R9 setup ratio 4");
    clk_low_seen = 0;
    repeat (20) @(negedge clk);
    check(clk_low_seen > 0, "R9 clk toggles at ratio 4", clk_low_seen, 1);
    check(clk_err == 0, "R9 clk high with tick", clk_err, 0);
    check(bus_err == 0, "R7 bus mirrors cpu", bus_err, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_all_codes();
    t_force();
    t_sources();
    t_boundary();
    t_clk_shape();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 150000);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule